// File: doc/BRIEF.md
# Round-Iterative 64-bit Block Encryption Core

This block encrypts one 64-bit block under an 80-bit key with a substitution-permutation network. A single round datapath is reused: every clock cycle the state is mixed with a round key, passed through sixteen 4-bit S-boxes in parallel and then rewired by a fixed bit permutation. After 31 such rounds, one last cycle XORs the state with a final round key. The round keys are not stored. They are derived one per cycle from an 80-bit key register, and that derivation uses the same S-box and a 5-bit round count.

The host places a plaintext and a key on the inputs and pulses `start` while the core is idle. The core accepts both on that edge and runs without further input. It then raises `done` for one cycle and keeps the ciphertext on `ct` until another start is accepted. A new start may be given in the same cycle that `done` is high, so blocks can follow each other back to back. A start given while a block is in progress has no effect.

Top module: `lwc_round_enc`

## Requirements
- R1: Each S-box maps input nibble values 0 through F, in that order, to the hex outputs C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. The datapath and the key update use the same mapping.
- R2: After the S-box layer, state bit i moves to bit 16*(i mod 4) + floor(i/4). Bits 0 and 63 keep their place.
- R3: A regular round XORs the round key into the state, then applies the S-box layer to all sixteen nibbles, then the permutation. There are 31 regular rounds, followed by an XOR with the 32nd round key and nothing else.
- R4: The round key is bits 79:16 of the key register, and the key register is loaded from `key`. After each regular round the register is rotated left by 61 places. Its bits 79:76 are then replaced by their S-box image. Finally the round number is XORed into bits 19:15, with the LSB of the round number at bit 15. The round number runs from 1 after the first round to 31 after the last.
- R5: `done` is high for exactly one cycle. It rises on the 32nd rising edge after the edge that accepted `start`.
- R6: A `start` pulse while a block is in progress changes neither the result nor the timing of `done`.
- R7: `ct` holds the last result while the core is idle until a new start is accepted. A start given in the cycle where `done` is high is accepted.
- R8: After reset, `done` is 0 and `ct` is all zeros.
- R9: With an all-zero key and an all-zero plaintext, `ct` is 5579C1387B228445. With an all-ones key and an all-zero plaintext, `ct` is E72C46C0F5945049. With an all-zero key and an all-ones plaintext, `ct` is A112FFC72F68417B. With all-ones for both, `ct` is 3333DCD3213210D2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; accepted only while idle |
| pt | input | 64 | Plaintext, sampled on the accepting edge |
| key | input | 80 | Key, sampled on the accepting edge |
| ct | output | 64 | Ciphertext, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle pulse when `ct` becomes valid |

## Verification
Two events can share a cycle. The first is completion together with a new request: the bench raises `start` with fresh operands in the same cycle it sees `done`. It then checks that `ct` in that cycle is still the finished result, and that the next block is correct and arrives exactly one latency later. The second is a start pulse arriving partway through a block: the bench drives different operands during a run and checks that the result and the `done` timing match the original block. A reference model in the bench, built arithmetically from R1 to R4, judges a long sweep of generated plaintexts and keys together with the known-answer vectors.

// File: rtl/lwc_round_enc.sv
module lwc_round_enc #(
  parameter int BLK_W   = 64,
  parameter int KEY_W   = 80,
  parameter int NROUNDS = 31,
  parameter int CNT_W   = 5,
  parameter int CTR_LSB = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] pt,
  input  logic [KEY_W-1:0] key,
  output logic [BLK_W-1:0] ct,
  output logic             done
);
  localparam int NIB = BLK_W / 4;
  localparam int ROT = KEY_W - 61;

  typedef enum logic [1:0] {IDLE, RUN, FIN} phase_t;

  phase_t           phase;
  logic [BLK_W-1:0] st;
  logic [KEY_W-1:0] kr;
  logic [CNT_W-1:0] rnd;
  logic             busy;

  function automatic logic [3:0] sbox(input logic [3:0] x);
    case (x)
      4'h0: sbox = 4'hC; 4'h1: sbox = 4'h5; 4'h2: sbox = 4'h6; 4'h3: sbox = 4'hB;
      4'h4: sbox = 4'h9; 4'h5: sbox = 4'h0; 4'h6: sbox = 4'hA; 4'h7: sbox = 4'hD;
      4'h8: sbox = 4'h3; 4'h9: sbox = 4'hE; 4'hA: sbox = 4'hF; 4'hB: sbox = 4'h8;
      4'hC: sbox = 4'h4; 4'hD: sbox = 4'h7; 4'hE: sbox = 4'h1; default: sbox = 4'h2;
    endcase
  endfunction

  logic [BLK_W-1:0] rk, mixed, subd, permd;
  assign rk    = kr[KEY_W-1 -: BLK_W];
  assign mixed = st ^ rk;

  for (genvar n = 0; n < NIB; n++) begin : g_sub
    assign subd[4*n +: 4] = sbox(mixed[4*n +: 4]);
  end

  for (genvar i = 0; i < BLK_W; i++) begin : g_perm
    assign permd[NIB*(i%4) + i/4] = subd[i];
  end

  logic [KEY_W-1:0] krot, knext;
  assign krot = {kr[ROT-1:0], kr[KEY_W-1:ROT]};

  always_comb begin
    knext = krot;
    knext[KEY_W-1 -: 4] = sbox(krot[KEY_W-1 -: 4]);
    knext[CTR_LSB +: CNT_W] = krot[CTR_LSB +: CNT_W] ^ rnd;
  end

  assign busy = (phase != IDLE);
  assign ct   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      st    <= '0;
      kr    <= '0;
      rnd   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        IDLE: if (start) begin
          st    <= pt;
          kr    <= key;
          rnd   <= CNT_W'(1);
          phase <= RUN;
        end
        RUN: begin
          st  <= permd;
          kr  <= knext;
          rnd <= rnd + 1'b1;
          if (rnd == CNT_W'(NROUNDS)) phase <= FIN;
        end
        default: begin
          st    <= st ^ rk;
          done  <= 1'b1;
          phase <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lwc_round_enc_chk.sv
module lwc_round_enc_chk #(
  parameter int BLK_W   = 64,
  parameter int NROUNDS = 31,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             busy,
  input logic [CNT_W-1:0] rnd,
  input logic [BLK_W-1:0] ct
);
  localparam int LAT = NROUNDS + 1;

  logic [7:0] lat;
  logic       trk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
      trk <= 1'b0;
    end else if (start && !busy) begin
      lat <= '0;
      trk <= 1'b1;
    end else if (trk) begin
      lat <= lat + 1'b1;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk && lat == 8'(LAT)));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (rnd != CNT_W'(1)));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ct));

  a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rnd == CNT_W'(1)));
endmodule

bind lwc_round_enc lwc_round_enc_chk #(
  .BLK_W(BLK_W), .NROUNDS(NROUNDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .busy(busy), .rnd(rnd), .ct(ct)
);

// File: tb/tb_lwc_round_enc.sv
module tb_lwc_round_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] pt = '0;
  logic [79:0] key = '0;
  logic [63:0] ct;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lwc_round_enc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pt(pt), .key(key),
    .ct(ct), .done(done)
  );

  localparam logic [63:0] SB = 64'hC56B90AD3EF84712;

  function automatic logic [3:0] sb(input logic [3:0] x);
    return SB[60 - 4*x +: 4];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] p, input logic [79:0] k);
    logic [63:0] s, t, u;
    logic [79:0] kk;
    s = p;
    kk = k;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ kk[79:16];
      for (int n = 0; n < 16; n++) t[4*n +: 4] = sb(s[4*n +: 4]);
      for (int j = 0; j < 64; j++) u[16*(j%4) + j/4] = t[j];
      s = u;
      kk = {kk[18:0], kk[79:19]};
      kk[79:76] = sb(kk[79:76]);
      kk[19:15] = kk[19:15] ^ 5'(r);
    end
    return s ^ kk[79:16];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Call at a negedge; returns at the negedge where done is seen. lat = negedges counted.
  task automatic run(input logic [63:0] p, input logic [79:0] k, output int lat,
                     input bit poke = 0);
    pt = p; key = k; start = 1'b1;
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin start = 1'b0; pt = ~p; key = ~k; end
      if (poke && lat == 10) begin start = 1'b1; pt = p ^ 64'h5A5A; key = k ^ 80'h1; end
      if (poke && lat == 11) start = 1'b0;
      if (done) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] p, exp_ct;
    logic [79:0] k;
    logic [63:0] lfsr;

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done after reset", 80'(done), 80'(0));
    chk(ct == 64'h0, "R8 ct after reset", 80'(ct), 80'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R9 known answers; the first also times R5
    run(64'h0, 80'h0, lat);
    chk(ct == 64'h5579C1387B228445, "R9 zero key zero pt", 80'(ct), 80'(64'h5579C1387B228445));
    chk(lat == 33, "R5 done on 32nd edge after accept", 80'(lat), 80'(33));
    @(negedge clk);
    chk(done == 1'b0, "R5 done lasts one cycle", 80'(done), 80'(0));
    for (int w = 0; w < 5; w++) begin
      chk(ct == 64'h5579C1387B228445, "R7 ct held while idle", 80'(ct), 80'(64'h5579C1387B228445));
      @(negedge clk);
    end
    run(64'h0, {80{1'b1}}, lat);
    chk(ct == 64'hE72C46C0F5945049, "R9 ones key zero pt", 80'(ct), 80'(64'hE72C46C0F5945049));
    @(negedge clk);
    run({64{1'b1}}, 80'h0, lat);
    chk(ct == 64'hA112FFC72F68417B, "R9 zero key ones pt", 80'(ct), 80'(64'hA112FFC72F68417B));
    run({64{1'b1}}, {80{1'b1}}, lat);   // back to back with previous done
    chk(ct == 64'h3333DCD3213210D2, "R9 ones key ones pt", 80'(ct), 80'(64'h3333DCD3213210D2));
    chk(lat == 33, "R7 start during done accepted", 80'(lat), 80'(33));

    // R6: start pulse during a run
    @(negedge clk);
    p = 64'h0123456789ABCDEF; k = 80'hFEDCBA98765432100F0F;
    run(p, k, lat, 1);
    exp_ct = model(p, k);
    chk(ct == exp_ct, "R6 result unchanged by busy start", 80'(ct), 80'(exp_ct));
    chk(lat == 33, "R6 done timing unchanged", 80'(lat), 80'(33));

    // R1 R2 R3 R4 sweep: single-bit keys/plaintexts, then generated ones
    for (int b = 0; b < 80; b++) begin
      k = 80'(1) << b;
      p = 64'(1) << (b % 64);
      run(p, k, lat);
      exp_ct = model(p, k);
      chk(ct == exp_ct, "R4 single key bit sweep", 80'(ct), 80'(exp_ct));
      chk(lat == 33, "R5 latency in sweep", 80'(lat), 80'(33));
    end
    lfsr = 64'h9E3779B97F4A7C15;
    for (int v = 0; v < 200; v++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      p = lfsr;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      k = {lfsr[15:0], lfsr ^ p};
      if (v % 2 == 1) @(negedge clk);
      run(p, k, lat);
      exp_ct = model(p, k);
      chk(ct == exp_ct, "R1 R2 R3 generated vector", 80'(ct), 80'(exp_ct));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule